// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block sits on the device side of a shared security-module interface and decides which of five software localities may drive it. Each locality sees its own window in a byte-wide register space, and the window's first byte is an access register. A locality asks for the interface by setting a request bit in that register. The current owner hands the interface back by setting the active bit in its own register.

While the interface is free, the highest-numbered waiting locality is granted on the next clock. The owner's register shows whether anyone else is waiting, so the owner can decide when to step aside. Every change of ownership produces a one-cycle locality-change pulse for the interrupt logic. The current owner is also exported as a valid flag and an index, for the logic that processes commands.

Top module: `locality_arbiter`

## Requirements
- R1: The locality index is address bits 14:12, and the access register is the byte whose address bits 11:0 are all zero. A write to locality 5, 6 or 7, or to any nonzero offset, changes nothing. A read there returns 0x00.
- R2: `reg_rdata` is loaded on each rising clock edge where `reg_rd` is high, from the state before that edge, and holds its value otherwise. Bit 7 of every mapped access register reads as 1 outside reset.
- R3: Bit 5 of an access register reads 1 only in the register of the locality that owns the interface.
- R4: Writing a byte with bit 1 set to a locality's access register queues a request for that locality, and bit 1 of a read shows that locality's queued request. A request written by the current owner is ignored.
- R5: When no locality owns the interface and requests are queued, the highest-numbered requester becomes owner on the next rising edge and its request is cleared. `owner_valid` and `owner_id` show the owner.
- R6: Bit 2 of the owner's access register reads 1 while any other locality has a request queued. Bit 2 reads 0 in the registers of all non-owners.
- R7: A write of a byte with bit 5 set by the owner to its own access register frees the interface at that edge. The next edge then grants the highest queued request.
- R8: A bit-5 write from a locality that is not the owner leaves ownership unchanged.
- R9: `loc_chg_evt` is high for exactly the cycle after each edge at which ownership changed, whether by a grant or by a release. It is otherwise low.
- R10: Synchronous reset leaves no owner, no queued requests, `reg_rdata` at 0x00 and `loc_chg_evt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 15 | Byte address, locality in bits 14:12 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_id | output | 3 | Index of the owning locality |
| loc_chg_evt | output | 1 | One-cycle pulse after each ownership change |

## Verification
On every cycle, the assertions check the following: the owner index stays in range, and the owner never holds a queued request of its own. A free interface with waiting requests is granted one edge later. A release attempt from a non-owner leaves the owner untouched. The change pulse coincides exactly with a change of owner, and reset clears all state. Other behaviour can only be shown by the bench's scenarios, because it needs chosen orderings of writes and reads. This covers the choice of the highest requester at a release, the pending and request bits as seen through register reads, the ignored writes to unmapped localities and offsets, and the holding of read data between reads.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // Bit positions inside every access register byte
  localparam int BIT_VALID  = 7;
  localparam int BIT_ACTIVE = 5;
  localparam int BIT_PEND   = 2;
  localparam int BIT_REQ    = 1;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/loc_decode.sv
module loc_decode #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 15,
  parameter int SEL_LSB = 12,
  parameter int LOC_W   = 3
) (
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_LOC-1:0] wr_hit,
  output logic [NUM_LOC-1:0] rd_hit
);
  localparam int SEL_MSB = SEL_LSB + LOC_W - 1;

  logic [LOC_W-1:0] sel;
  logic             off_zero;
  logic             hi_ok;

  assign sel      = addr[SEL_MSB:SEL_LSB];
  assign off_zero = (addr[SEL_LSB-1:0] == '0);

  generate
    if (ADDR_W > SEL_MSB + 1) begin : g_hi
      assign hi_ok = (addr[ADDR_W-1:SEL_MSB+1] == '0);
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_hit
      logic match;
      assign match     = off_zero && hi_ok && (sel == LOC_W'(g));
      assign wr_hit[g] = wr && match;
      assign rd_hit[g] = rd && match;
    end
  endgenerate
endmodule

// File: rtl/loc_prio.sv
module loc_prio #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic [NUM_LOC-1:0] req,
  output logic               any,
  output logic [LOC_W-1:0]   idx
);
  // Ascending scan: the last set bit found is the highest index
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req[i]) idx = LOC_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/loc_owner.sv
module loc_owner
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] wr_hit,
  input  byte_t              wdata,
  output logic               owner_vld,
  output logic [LOC_W-1:0]   owner_id,
  output logic [NUM_LOC-1:0] req_q,
  output logic               chg_evt
);
  logic [NUM_LOC-1:0] owner_oh;
  logic [NUM_LOC-1:0] set_req;
  logic [NUM_LOC-1:0] grant_mask;
  logic               pr_any;
  logic [LOC_W-1:0]   pr_idx;
  logic               rel;
  logic               grant;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata[7:6], wdata[4:2], wdata[0]};

  loc_prio #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_prio (
    .req (req_q),
    .any (pr_any),
    .idx (pr_idx)
  );

  assign owner_oh   = owner_vld ? (NUM_LOC'(1) << owner_id) : '0;
  assign set_req    = wdata[BIT_REQ] ? (wr_hit & ~owner_oh) : '0;
  assign rel        = wdata[BIT_ACTIVE] && |(wr_hit & owner_oh);
  assign grant      = !owner_vld && pr_any;
  assign grant_mask = grant ? (NUM_LOC'(1) << pr_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_vld <= 1'b0;
      owner_id  <= '0;
      req_q     <= '0;
      chg_evt   <= 1'b0;
    end else begin
      if (rel) begin
        owner_vld <= 1'b0;
      end else if (grant) begin
        owner_vld <= 1'b1;
        owner_id  <= pr_idx;
      end
      req_q   <= (req_q | set_req) & ~grant_mask;
      chg_evt <= rel || grant;
    end
  end
endmodule

// File: rtl/loc_readback.sv
module loc_readback
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [NUM_LOC-1:0] rd_hit,
  input  logic               owner_vld,
  input  logic [LOC_W-1:0]   owner_id,
  input  logic [NUM_LOC-1:0] req_q,
  output byte_t              rdata
);
  byte_t acc [NUM_LOC];
  byte_t mux;

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_acc
      logic is_own;
      logic others;
      assign is_own = owner_vld && (owner_id == LOC_W'(g));
      assign others = |(req_q & ~(NUM_LOC'(1) << g));
      always_comb begin
        acc[g]             = '0;
        acc[g][BIT_VALID]  = 1'b1;
        acc[g][BIT_ACTIVE] = is_own;
        acc[g][BIT_PEND]   = is_own && others;
        acc[g][BIT_REQ]    = req_q[g];
      end
    end
  endgenerate

  always_comb begin
    mux = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (rd_hit[i]) mux = mux | acc[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux;
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int SEL_LSB = 12,
  parameter int LOC_W   = $clog2(NUM_LOC),
  parameter int ADDR_W  = SEL_LSB + LOC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              owner_valid,
  output logic [LOC_W-1:0]  owner_id,
  output logic              loc_chg_evt
);
  logic [NUM_LOC-1:0] wr_hit;
  logic [NUM_LOC-1:0] rd_hit;
  logic [NUM_LOC-1:0] req_q;

  loc_decode #(
    .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .LOC_W(LOC_W)
  ) u_dec (
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  loc_owner #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_own (
    .clk       (clk),
    .rst       (rst),
    .wr_hit    (wr_hit),
    .wdata     (reg_wdata),
    .owner_vld (owner_valid),
    .owner_id  (owner_id),
    .req_q     (req_q),
    .chg_evt   (loc_chg_evt)
  );

  loc_readback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .rd        (reg_rd),
    .rd_hit    (rd_hit),
    .owner_vld (owner_valid),
    .owner_id  (owner_id),
    .req_q     (req_q),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/locality_arbiter_chk.sv
module locality_arbiter_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_LOC-1:0] wr_hit,
  input logic [7:0]         reg_wdata,
  input logic [NUM_LOC-1:0] req_q,
  input logic               owner_valid,
  input logic [LOC_W-1:0]   owner_id,
  input logic               loc_chg_evt
);
  logic [NUM_LOC-1:0] own_oh;
  assign own_oh = owner_valid ? (NUM_LOC'(1) << owner_id) : '0;

  AST_OWNER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    owner_valid |-> (int'(owner_id) < NUM_LOC)); // R5

  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    (!owner_valid && |req_q) |=> owner_valid); // R5

  AST_OWNER_HOLDS_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    owner_valid |-> !req_q[owner_id]); // R4

  AST_FOREIGN_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (owner_valid && reg_wdata[5] && |(wr_hit & ~own_oh))
      |=> (owner_valid && owner_id == $past(owner_id))); // R8

  AST_EVT_MARKS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    loc_chg_evt == ((owner_valid != $past(owner_valid)) ||
                    (owner_valid && owner_id != $past(owner_id)))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!owner_valid && req_q == '0 && !loc_chg_evt)); // R10
endmodule

bind locality_arbiter locality_arbiter_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_hit      (wr_hit),
  .reg_wdata   (reg_wdata),
  .req_q       (req_q),
  .owner_valid (owner_valid),
  .owner_id    (owner_id),
  .loc_chg_evt (loc_chg_evt)
);

// File: tb/tb_locality_arbiter.sv
module tb_locality_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [1:0] OP_ID = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [14:0] addr;
    logic [7:0]  wd;
    logic        ev;
    logic [2:0]  eid;
    logic        eevt;
    logic [7:0]  erd;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{OP_RD, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 8'h80}, // 0
    '{OP_WR, 15'h2000, 8'h02, 1'b0, 3'd0, 1'b0, 8'h00}, // 1 loc2 request
    '{OP_ID, 15'h0000, 8'h00, 1'b1, 3'd2, 1'b1, 8'h00}, // 2 grant 2
    '{OP_ID, 15'h0000, 8'h00, 1'b1, 3'd2, 1'b0, 8'h00}, // 3
    '{OP_RD, 15'h2000, 8'h00, 1'b1, 3'd2, 1'b0, 8'hA0}, // 4
    '{OP_WR, 15'h1000, 8'h02, 1'b1, 3'd2, 1'b0, 8'h00}, // 5 loc1 request
    '{OP_WR, 15'h3000, 8'h02, 1'b1, 3'd2, 1'b0, 8'h00}, // 6 loc3 request
    '{OP_RD, 15'h2000, 8'h00, 1'b1, 3'd2, 1'b0, 8'hA4}, // 7 pending
    '{OP_RD, 15'h1000, 8'h00, 1'b1, 3'd2, 1'b0, 8'h82}, // 8 own request
    '{OP_WR, 15'h1000, 8'h20, 1'b1, 3'd2, 1'b0, 8'h00}, // 9 foreign release
    '{OP_WR, 15'h2000, 8'h02, 1'b1, 3'd2, 1'b0, 8'h00}, // 10 owner request
    '{OP_RD, 15'h2000, 8'h00, 1'b1, 3'd2, 1'b0, 8'hA4}, // 11
    '{OP_WR, 15'h2000, 8'h20, 1'b0, 3'd0, 1'b1, 8'h00}, // 12 release
    '{OP_ID, 15'h0000, 8'h00, 1'b1, 3'd3, 1'b1, 8'h00}, // 13 grant 3
    '{OP_RD, 15'h3000, 8'h00, 1'b1, 3'd3, 1'b0, 8'hA4}, // 14
    '{OP_RD, 15'h0000, 8'h00, 1'b1, 3'd3, 1'b0, 8'h80}, // 15
    '{OP_WR, 15'h3000, 8'h20, 1'b0, 3'd0, 1'b1, 8'h00}, // 16 release
    '{OP_ID, 15'h0000, 8'h00, 1'b1, 3'd1, 1'b1, 8'h00}, // 17 grant 1
    '{OP_RD, 15'h1000, 8'h00, 1'b1, 3'd1, 1'b0, 8'hA0}, // 18
    '{OP_WR, 15'h5000, 8'h02, 1'b1, 3'd1, 1'b0, 8'h00}, // 19 loc5 write
    '{OP_RD, 15'h5000, 8'h00, 1'b1, 3'd1, 1'b0, 8'h00}, // 20
    '{OP_WR, 15'h1018, 8'h20, 1'b1, 3'd1, 1'b0, 8'h00}, // 21 other offset
    '{OP_RD, 15'h1004, 8'h00, 1'b1, 3'd1, 1'b0, 8'h00}, // 22
    '{OP_RD, 15'h4000, 8'h00, 1'b1, 3'd1, 1'b0, 8'h80}, // 23
    '{OP_WR, 15'h1000, 8'h20, 1'b0, 3'd0, 1'b1, 8'h00}, // 24 release
    '{OP_ID, 15'h0000, 8'h00, 1'b0, 3'd0, 1'b0, 8'h00}, // 25 nothing queued
    '{OP_WR, 15'h4000, 8'h02, 1'b0, 3'd0, 1'b0, 8'h00}, // 26 loc4 request
    '{OP_ID, 15'h0000, 8'h00, 1'b1, 3'd4, 1'b1, 8'h00}  // 27 grant 4
  };

  function automatic string tag_of(input int i);
    case (i)
      0:                         return "R2";
      1, 5, 6, 8, 10, 11, 26:    return "R4";
      2, 3, 27:                  return "R5";
      4, 15, 18:                 return "R3";
      7, 14:                     return "R6";
      9:                         return "R8";
      12, 13, 17:                return "R7";
      16, 24:                    return "R9";
      default:                   return "R1";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [14:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        owner_valid;
  logic [2:0]  owner_id;
  logic        loc_chg_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  locality_arbiter dut (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .owner_valid (owner_valid),
    .owner_id    (owner_id),
    .loc_chg_evt (loc_chg_evt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [14:0] a, input logic [7:0] d);
    reg_wr    = (op == OP_WR);
    reg_rd    = (op == OP_RD);
    reg_addr  = a;
    reg_wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while in reset
    check(owner_valid == 1'b0, "R10", int'(owner_valid), 0);
    check(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
    check(loc_chg_evt == 1'b0, "R10", int'(loc_chg_evt), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].op, TBL[i].addr, TBL[i].wd);
      @(negedge clk);
      check(owner_valid == TBL[i].ev, tag_of(i), int'(owner_valid), int'(TBL[i].ev));
      if (TBL[i].ev)
        check(owner_id == TBL[i].eid, tag_of(i), int'(owner_id), int'(TBL[i].eid));
      check(loc_chg_evt == TBL[i].eevt, "R9", int'(loc_chg_evt), int'(TBL[i].eevt));
      if (TBL[i].op == OP_RD)
        check(reg_rdata == TBL[i].erd, tag_of(i), int'(reg_rdata), int'(TBL[i].erd));
    end
    drive(OP_ID, '0, '0);

    // R2: read data held since the last read (row 23)
    @(negedge clk);
    check(reg_rdata == 8'h80, "R2", int'(reg_rdata), 8'h80);

    // R10: reset while locality 4 owns and locality 0 waits
    drive(OP_WR, 15'h0000, 8'h02);
    @(negedge clk);
    drive(OP_RD, 15'h4000, 8'h00);
    @(negedge clk);
    drive(OP_ID, '0, '0);
    check(reg_rdata == 8'hA4, "R6", int'(reg_rdata), 8'hA4);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(owner_valid == 1'b0, "R10", int'(owner_valid), 0);
    check(reg_rdata == 8'h00, "R10", int'(reg_rdata), 0);
    check(loc_chg_evt == 1'b0, "R10", int'(loc_chg_evt), 0);
    rst = 1'b0;
    drive(OP_RD, 15'h0000, 8'h00);
    @(negedge clk);
    drive(OP_ID, '0, '0);
    check(reg_rdata == 8'h80, "R10", int'(reg_rdata), 8'h80);
    @(negedge clk);
    check(owner_valid == 1'b0, "R10", int'(owner_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule